// File: doc/BRIEF.md
# Dithered Pixel Generator and Bitmap Packer

This block turns a stream of one-bit video decisions into packed bitmap words. It holds a small table of dither thresholds, loaded through one byte-wide write port with an address, and applies them cyclically: each pixel gets the next threshold. The current threshold is presented on an output, where an external comparison path uses it. Each pixel strobe brings back one decision bit.

The block chooses the source of each pixel: either the comparator result or an external bypass bit. It can optionally invert the pixel. It then packs the pixels into a word, with the earliest pixel in the least significant bit. When a word is full it is latched, and a ready flag is raised for a DMA engine to collect it.

Reading the word is signalled by a one-cycle read strobe. The read clears the ready flag and restarts the pixel count, so any partly built word is dropped. If a second word completes while the first is still unread, a sticky overflow flag is set. A window-start pulse from the video timing logic sends the threshold sequence back to its first entry.

Top module: `dither_pixel_packer`

## Requirements
- R1: A cycle with `dth_wr_en` high writes `dth_wr_data` into table entry `dth_wr_addr` (entries 0 to 7). `dth_level` always shows the entry selected by the current dither index.
- R2: `win_start` sets the dither index to 0 on the next clock edge. This takes priority over a `pix_strobe` in the same cycle.
- R3: Each `pix_strobe` without `win_start` advances the dither index by one, modulo 8, so that entry 7 is followed by entry 0.
- R4: With `ctl_bypass` at 0 the pixel is `cmp_bit`. With `ctl_bypass` at 1 the pixel is `byp_bit`, and `cmp_bit` has no effect on the packed word.
- R5: With `ctl_invert` at 1 every pixel is inverted after source selection. With `ctl_invert` at 0 pixels pass unchanged.
- R6: The first pixel after a clear goes to bit 0 and the sixteenth to bit 15. On the clock edge that takes the sixteenth pixel, `word_out` takes the full word and `word_ready` goes to 1.
- R7: A `word_rd` cycle clears `word_ready` and restarts the pixel count, discarding a partial word, and leaves `word_out` unchanged. A pixel strobed in the same cycle as `word_rd` becomes bit 0 of the next word.
- R8: `overflow` goes to 1 when a word completes while `word_ready` is still 1 with no read in that cycle. Once set, it stays at 1 until reset.
- R9: After reset the dither index, every table entry, `word_out`, `word_ready` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dth_wr_en | input | 1 | Dither table write strobe |
| dth_wr_addr | input | 3 | Dither table entry address |
| dth_wr_data | input | 8 | Dither value to write |
| ctl_invert | input | 1 | Invert every generated pixel |
| ctl_bypass | input | 1 | Take pixels from `byp_bit` instead of `cmp_bit` |
| win_start | input | 1 | Video window start; restarts the dither sequence |
| pix_strobe | input | 1 | One pixel per high cycle |
| cmp_bit | input | 1 | Comparator decision for the current pixel |
| byp_bit | input | 1 | External bypass pixel |
| word_rd | input | 1 | One-cycle read of the packed word |
| dth_level | output | 8 | Dither threshold for the current pixel |
| word_out | output | 16 | Last completed bitmap word |
| word_ready | output | 1 | Completed word waiting to be read |
| overflow | output | 1 | Sticky: a word was completed over an unread one |

## Verification
The bound checker looks at every cycle. It checks that the dither index steps and wraps on strobes and returns to zero on window start. It also checks that the threshold output holds when nothing moves it, and that a read clears the ready flag and the pixel count. Finally, it checks that the overflow flag is sticky and only rises over an unread word, and that the packed word changes only on a pixel strobe. The actual bit order within a word, and the pixel value chosen by bypass and inversion, depend on input patterns. So do the values loaded into the table. Only the bench's directed scenarios, which compare whole words against patterns computed independently, can show these.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
   typedef enum logic {SRC_COMPARE = 1'b0, SRC_EXTERNAL = 1'b1} pix_src_e;

   function automatic logic apply_polarity(input logic raw, input logic inv);
      return raw ^ inv;
   endfunction
endpackage

// File: rtl/dpp_dither_table.sv
module dpp_dither_table #(
   parameter int VAL_W = 8,
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [VAL_W-1:0] wr_data,
   input  logic             win_start,
   input  logic             pix_strobe,
   output logic [IDX_W-1:0] idx,
   output logic [VAL_W-1:0] level
);
   logic [VAL_W-1:0] entry [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            entry[e] <= '0;
         else if (wr_en && (wr_addr == IDX_W'(e)))
            entry[e] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (win_start)
         idx <= '0;
      else if (pix_strobe)
         idx <= IDX_W'(idx + 1'b1);
   end

   assign level = entry[idx];
endmodule

// File: rtl/dpp_pixel_sel.sv
module dpp_pixel_sel
   import dpp_pkg::*;
#(
   parameter bit HAS_BYPASS = 1'b1
) (
   input  logic cmp_bit,
   input  logic byp_bit,
   input  logic bypass,
   input  logic invert,
   output logic pix
);
   pix_src_e src;
   logic     raw;

   if (HAS_BYPASS) begin : g_bypass
      assign src = bypass ? SRC_EXTERNAL : SRC_COMPARE;
      assign raw = (src == SRC_EXTERNAL) ? byp_bit : cmp_bit;
   end else begin : g_no_bypass
      logic unused_byp;
      assign unused_byp = byp_bit ^ bypass;
      assign src = SRC_COMPARE;
      assign raw = cmp_bit;
   end

   assign pix = apply_polarity(raw, invert);
endmodule

// File: rtl/dpp_packer.sv
module dpp_packer #(
   parameter int WORD_W = 16,
   localparam int CNT_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_strobe,
   input  logic              pix,
   input  logic              word_rd,
   output logic [WORD_W-1:0] word_out,
   output logic              word_ready,
   output logic              overflow,
   output logic [CNT_W-1:0]  cnt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] acc;
   logic [WORD_W-1:0] acc_nxt;
   logic [CNT_W-1:0]  slot;
   logic              completes;

   assign slot      = word_rd ? '0 : cnt;
   assign completes = pix_strobe && !word_rd && (cnt == LAST);

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      assign acc_nxt[b] = (pix_strobe && (slot == CNT_W'(b))) ? pix : acc[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc        <= '0;
         cnt        <= '0;
         word_out   <= '0;
         word_ready <= 1'b0;
         overflow   <= 1'b0;
      end else begin
         acc <= acc_nxt;
         if (word_rd) begin
            word_ready <= 1'b0;
            cnt        <= pix_strobe ? CNT_W'(1) : '0;
         end else if (pix_strobe) begin
            if (completes) begin
               word_out   <= acc_nxt;
               word_ready <= 1'b1;
               cnt        <= '0;
               if (word_ready)
                  overflow <= 1'b1;
            end else begin
               cnt <= CNT_W'(cnt + 1'b1);
            end
         end
      end
   end
endmodule

// File: rtl/dither_pixel_packer.sv
module dither_pixel_packer #(
   parameter int VAL_W      = 8,
   parameter int DEPTH      = 8,
   parameter int WORD_W     = 16,
   parameter bit HAS_BYPASS = 1'b1,
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int CNT_W     = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dth_wr_en,
   input  logic [IDX_W-1:0]  dth_wr_addr,
   input  logic [VAL_W-1:0]  dth_wr_data,
   input  logic              ctl_invert,
   input  logic              ctl_bypass,
   input  logic              win_start,
   input  logic              pix_strobe,
   input  logic              cmp_bit,
   input  logic              byp_bit,
   input  logic              word_rd,
   output logic [VAL_W-1:0]  dth_level,
   output logic [WORD_W-1:0] word_out,
   output logic              word_ready,
   output logic              overflow
);
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("dither_pixel_packer: DEPTH must be a power of two, at least 2");
   end
   if (WORD_W < 2 || (1 << CNT_W) != WORD_W) begin : g_bad_word
      $error("dither_pixel_packer: WORD_W must be a power of two, at least 2");
   end
   if (VAL_W < 1) begin : g_bad_val
      $error("dither_pixel_packer: VAL_W must be positive");
   end

   logic [IDX_W-1:0] dth_idx;
   logic [CNT_W-1:0] pix_cnt;
   logic             pix_val;

   dpp_dither_table #(.VAL_W(VAL_W), .DEPTH(DEPTH)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (dth_wr_en),
      .wr_addr    (dth_wr_addr),
      .wr_data    (dth_wr_data),
      .win_start  (win_start),
      .pix_strobe (pix_strobe),
      .idx        (dth_idx),
      .level      (dth_level)
   );

   dpp_pixel_sel #(.HAS_BYPASS(HAS_BYPASS)) u_sel (
      .cmp_bit (cmp_bit),
      .byp_bit (byp_bit),
      .bypass  (ctl_bypass),
      .invert  (ctl_invert),
      .pix     (pix_val)
   );

   dpp_packer #(.WORD_W(WORD_W)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_strobe (pix_strobe),
      .pix        (pix_val),
      .word_rd    (word_rd),
      .word_out   (word_out),
      .word_ready (word_ready),
      .overflow   (overflow),
      .cnt        (pix_cnt)
   );
endmodule

// File: rtl/dpp_checker.sv
module dpp_checker #(
   parameter int VAL_W  = 8,
   parameter int IDX_W  = 3,
   parameter int CNT_W  = 4,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              win_start,
   input logic              pix_strobe,
   input logic              dth_wr_en,
   input logic              word_rd,
   input logic [IDX_W-1:0]  idx,
   input logic [CNT_W-1:0]  cnt,
   input logic [VAL_W-1:0]  dth_level,
   input logic [WORD_W-1:0] word_out,
   input logic              word_ready,
   input logic              overflow
);
   AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      win_start |=> (idx == '0)); // R2

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_strobe && !win_start) |=> (idx == IDX_W'($past(idx) + 1'b1))); // R3

   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_strobe && !win_start) |=> $stable(idx)); // R3

   AST_LEVEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_strobe && !win_start && !dth_wr_en) |=> $stable(dth_level)); // R1

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      word_rd |=> (!word_ready && cnt <= CNT_W'(1))); // R7

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_strobe |=> $stable(word_out)); // R6

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow); // R8

   AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(word_ready)); // R8
endmodule

bind dither_pixel_packer dpp_checker #(
   .VAL_W(VAL_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .WORD_W(WORD_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .win_start  (win_start),
   .pix_strobe (pix_strobe),
   .dth_wr_en  (dth_wr_en),
   .word_rd    (word_rd),
   .idx        (dth_idx),
   .cnt        (pix_cnt),
   .dth_level  (dth_level),
   .word_out   (word_out),
   .word_ready (word_ready),
   .overflow   (overflow)
);

// File: tb/dither_pixel_packer_tb.sv
module dither_pixel_packer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dth_wr_en = 1'b0;
   logic [2:0]  dth_wr_addr = '0;
   logic [7:0]  dth_wr_data = '0;
   logic        ctl_invert = 1'b0;
   logic        ctl_bypass = 1'b0;
   logic        win_start = 1'b0;
   logic        pix_strobe = 1'b0;
   logic        cmp_bit = 1'b0;
   logic        byp_bit = 1'b0;
   logic        word_rd = 1'b0;
   logic [7:0]  dth_level;
   logic [15:0] word_out;
   logic        word_ready;
   logic        overflow;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   dither_pixel_packer u_dut (
      .clk(clk), .rst_n(rst_n), .dth_wr_en(dth_wr_en), .dth_wr_addr(dth_wr_addr),
      .dth_wr_data(dth_wr_data), .ctl_invert(ctl_invert), .ctl_bypass(ctl_bypass),
      .win_start(win_start), .pix_strobe(pix_strobe), .cmp_bit(cmp_bit),
      .byp_bit(byp_bit), .word_rd(word_rd), .dth_level(dth_level),
      .word_out(word_out), .word_ready(word_ready), .overflow(overflow)
   );

   function automatic logic [7:0] tv(input int i);
      return 8'(8'h13 + 8'h21 * i);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pix(input logic c, input logic b);
      @(negedge clk);
      pix_strobe = 1'b1; cmp_bit = c; byp_bit = b;
      @(negedge clk);
      pix_strobe = 1'b0;
   endtask

   task automatic send_word(input logic [15:0] cv, input logic [15:0] bv);
      for (int i = 0; i < 16; i++) pix(cv[i], bv[i]);
   endtask

   task automatic rd_word();
      @(negedge clk);
      word_rd = 1'b1;
      @(negedge clk);
      word_rd = 1'b0;
   endtask

   task automatic t_reset();
      chk("R9 word_ready", 32'(word_ready), 0);
      chk("R9 overflow", 32'(overflow), 0);
      chk("R9 word_out", 32'(word_out), 0);
      chk("R9 dth_level", 32'(dth_level), 0);
   endtask

   task automatic t_table();
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         dth_wr_en = 1'b1; dth_wr_addr = 3'(i); dth_wr_data = tv(i);
      end
      @(negedge clk);
      dth_wr_en = 1'b0;
      chk("R1 entry0 after load", 32'(dth_level), 32'(tv(0)));
      for (int k = 1; k <= 9; k++) begin
         pix(1'b0, 1'b0);
         chk("R3 step/wrap", 32'(dth_level), 32'(tv(k % 8)));
      end
      @(negedge clk); win_start = 1'b1;
      @(negedge clk); win_start = 1'b0;
      chk("R2 window start", 32'(dth_level), 32'(tv(0)));
      pix(1'b0, 1'b0); pix(1'b0, 1'b0);
      chk("R1 entry2", 32'(dth_level), 32'(tv(2)));
      @(negedge clk); win_start = 1'b1; pix_strobe = 1'b1;
      @(negedge clk); win_start = 1'b0; pix_strobe = 1'b0;
      chk("R2 priority over strobe", 32'(dth_level), 32'(tv(0)));
      rd_word();
      chk("R7 no word from partial", 32'(word_ready), 0);
   endtask

   task automatic t_compare_path();
      ctl_bypass = 1'b0; ctl_invert = 1'b0;
      send_word(16'hA5C3, ~16'hA5C3);
      chk("R6 ready after 16", 32'(word_ready), 1);
      chk("R6/R4 lsb-first word", 32'(word_out), 32'h0000A5C3);
      rd_word();
      chk("R7 ready cleared", 32'(word_ready), 0);
      chk("R7 word kept", 32'(word_out), 32'h0000A5C3);
   endtask

   task automatic t_bypass();
      ctl_bypass = 1'b1; ctl_invert = 1'b0;
      send_word(16'h1234, 16'h0F0F);
      chk("R4 bypass ignores compare", 32'(word_out), 32'h00000F0F);
      rd_word();
   endtask

   task automatic t_invert();
      ctl_bypass = 1'b0; ctl_invert = 1'b1;
      send_word(16'h00FF, 16'h5555);
      chk("R5 invert compare", 32'(word_out), 32'h0000FF00);
      rd_word();
      ctl_bypass = 1'b1;
      send_word(16'hFFFF, 16'h8001);
      chk("R5 invert bypass", 32'(word_out), 32'h00007FFE);
      rd_word();
      ctl_bypass = 1'b0; ctl_invert = 1'b0;
   endtask

   task automatic t_partial();
      for (int i = 0; i < 5; i++) pix(1'b1, 1'b0);
      rd_word();
      send_word(16'h8000, 16'h0000);
      chk("R7 partial discarded", 32'(word_out), 32'h00008000);
      chk("R6 ready", 32'(word_ready), 1);
      rd_word();
   endtask

   task automatic t_read_with_strobe();
      for (int i = 0; i < 3; i++) pix(1'b1, 1'b0);
      @(negedge clk);
      word_rd = 1'b1; pix_strobe = 1'b1; cmp_bit = 1'b1;
      @(negedge clk);
      word_rd = 1'b0; pix_strobe = 1'b0;
      for (int i = 0; i < 15; i++) pix(1'b0, 1'b1);
      chk("R7 same-cycle pixel is bit 0", 32'(word_out), 32'h00000001);
      chk("R8 no overflow yet", 32'(overflow), 0);
      rd_word();
   endtask

   task automatic t_overflow();
      send_word(16'h1111, 16'h0000);
      chk("R8 single word no overflow", 32'(overflow), 0);
      send_word(16'h2222, 16'h0000);
      chk("R8 overflow set", 32'(overflow), 1);
      chk("R8 newest word held", 32'(word_out), 32'h00002222);
      rd_word();
      chk("R8 overflow sticky", 32'(overflow), 1);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_table();
      t_compare_path();
      t_bypass();
      t_invert();
      t_partial();
      t_read_with_strobe();
      t_overflow();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule